// File: doc/BRIEF.md
# Strobed Serialising Output Port

This block turns transfer words written by a processor-side register interface into a stream of narrow pin values. Each accepted word is cut into elements of the pin width and the elements leave on the pins one at a time, lowest-numbered element first. An element leaves only on a port clock launch, which is a one-cycle `port_tick` pulse in the system clock domain. The datapath is double buffered. A one-word transfer register takes writes. Behind it a shift FIFO feeds the pins. While the FIFO sends one word, the writer can already park the next.

Two strobes can pace the stream, chosen by a two-bit mode taken at configuration time. One is an outgoing ready that advertises data. The other is an incoming ready that must be high for an element to launch. A write can also carry a launch time. The whole output then freezes with `rdy_out` low until the external port counter equals that time on a launch tick. When no element may launch, the pins hold their last value. A configuration pulse clears both buffers, takes the new mode and places an initial value on the pins.

Top module: `strobed_ser_out`

## Requirements
- R1: A word is sent as XFER_W/PIN_W elements. Element k is word bits [k*PIN_W +: PIN_W], and k=0 is sent first. A launch at a clock edge makes that element appear on `pins` after the same edge.
- R2: A word accepted at edge n can launch no earlier than edge n+2. If the transfer register is full when the last element of the FIFO launches, the next word's first element can launch on the very next tick, with no gap.
- R3: `wr_ready` is high exactly when the transfer register is empty and no timed write is pending. A write is accepted at an edge where `wr_valid` and `wr_ready` are both high.
- R4: Mode 2'b00 (implicit): an element launches on every tick while the FIFO holds data, `rdy_in` is ignored, and `rdy_out` stays low.
- R5: Mode 2'b01 (master): `rdy_in` is ignored. `rdy_out` is high exactly when the FIFO holds data and no timed write is pending.
- R6: Mode 2'b10 (slave): a tick launches an element only if `rdy_in` is high at that edge. `rdy_out` stays low.
- R7: Mode 2'b11 (handshake): launches are gated by `rdy_in` as in R6, and `rdy_out` behaves as in R5. Mode bit 0 selects driving `rdy_out`; mode bit 1 selects obeying `rdy_in`.
- R8: When the FIFO is empty, or the ready conditions fail, `pins` keep their last driven value.
- R9: A write with `wr_timed` high records `wr_time` and holds back all launches, keeping `rdy_out` low. The hold ends on the first tick where `port_count` equals the recorded time, and that tick may launch.
- R10: Reset gives pins 0, empty buffers and mode 2'b00. A `cfg_load` pulse sets `pins` to `cfg_init` after the edge, empties both buffers, drops any pending timed write and takes `cfg_mode`.
- R11: Without `port_tick`, no element launches and `pins` do not change (except by `cfg_load`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Configure pulse: clear buffers, take mode, load initial pins |
| cfg_mode | input | 2 | Ready mode (bit 0 drive rdy_out, bit 1 obey rdy_in) |
| cfg_init | input | PIN_W | Initial pin value applied by cfg_load |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Transfer register can accept a word |
| wr_data | input | XFER_W | Transfer word |
| wr_timed | input | 1 | Write carries a launch time |
| wr_time | input | TIME_W | Port counter value at which the timed launch may start |
| port_tick | input | 1 | Port clock launch enable, one cycle wide |
| port_count | input | TIME_W | Port counter value |
| rdy_in | input | 1 | Incoming ready strobe |
| rdy_out | output | 1 | Outgoing ready strobe |
| pins | output | PIN_W | Driven pin value |

## Verification
The bench goes after the refill edge. If the transfer register were copied one cycle late, a gap would show in back-to-back streams. If it were copied too early, the element order would break. It sweeps all four modes against sparse ticks and a patterned incoming ready. A design that ignored or misapplied a mode bit would launch elements a slave must hold back, or would raise the strobe in implicit mode. Timed writes are checked for a premature first element, for `rdy_out` rising before the match, and for a second write slipping in while the first is pending. Starved and unticked stretches catch pins that drift instead of holding.

// File: rtl/osp_pkg.sv
package osp_pkg;

  // bit 0: block drives the outgoing ready, bit 1: block obeys the incoming ready
  typedef enum logic [1:0] {
    RDY_NONE   = 2'b00,
    RDY_MASTER = 2'b01,
    RDY_SLAVE  = 2'b10,
    RDY_BOTH   = 2'b11
  } rdy_mode_e;

  localparam int unsigned DEF_TIME_W = 16;

endpackage

// File: rtl/osp_xfer_reg.sv
module osp_xfer_reg #(
  parameter int unsigned XFER_W = 32,
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              wr_valid,
  input  logic [XFER_W-1:0] wr_data,
  input  logic              wr_timed,
  input  logic [TIME_W-1:0] wr_time,
  input  logic              take,
  input  logic              tw_fire,
  output logic              wr_ready,
  output logic [XFER_W-1:0] xr_data,
  output logic              xr_full,
  output logic              tw_pend,
  output logic [TIME_W-1:0] tw_target
);

  logic accept;
  logic full_d, pend_d;
  logic data_en, time_en;

  assign wr_ready = !xr_full && !tw_pend;
  assign accept   = wr_valid && wr_ready;
  assign data_en  = accept;
  assign time_en  = accept && wr_timed;

  always_comb begin
    full_d = xr_full;
    pend_d = tw_pend;
    if (take)    full_d = 1'b0;
    if (accept)  full_d = 1'b1;
    if (time_en) pend_d = 1'b1;
    if (tw_fire) pend_d = 1'b0;
    if (cfg_load) begin
      full_d = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr_full <= 1'b0;
      tw_pend <= 1'b0;
    end else begin
      xr_full <= full_d;
      tw_pend <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr_data <= '0;
    end else if (data_en) begin
      xr_data <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tw_target <= '0;
    end else if (time_en) begin
      tw_target <= wr_time;
    end
  end

  // R3 / R9: a timed write blocks the next write
  p_timed_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_timed && !cfg_load) |=> !wr_ready);

  // R3: an accepted write fills the register
  p_accept_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !cfg_load) |=> xr_full);

endmodule

// File: rtl/osp_shifter.sv
module osp_shifter #(
  parameter int unsigned PIN_W  = 4,
  parameter int unsigned XFER_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [PIN_W-1:0]  cfg_init,
  input  logic              go,
  input  logic              xr_full,
  input  logic [XFER_W-1:0] xr_data,
  output logic              take,
  output logic              has_data,
  output logic [PIN_W-1:0]  pins
);

  localparam int unsigned NELEM = XFER_W / PIN_W;
  localparam int unsigned CNT_W = $clog2(NELEM + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NELEM);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [XFER_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PIN_W-1:0]  pins_q, pins_d;
  logic              last_out;
  logic              sh_en, pins_en;

  assign has_data = (cnt_q != '0);
  assign last_out = go && (cnt_q == ONE_CNT);
  assign take     = xr_full && (!has_data || last_out);
  assign sh_en    = go || take || cfg_load;
  assign pins_en  = go || cfg_load;
  assign pins     = pins_q;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    pins_d = pins_q;
    if (go) begin
      pins_d = sh_q[PIN_W-1:0];
      sh_d   = sh_q >> PIN_W;
      cnt_d  = cnt_q - ONE_CNT;
    end
    if (take) begin
      sh_d  = xr_data;
      cnt_d = FULL_CNT;
    end
    if (cfg_load) begin
      pins_d = cfg_init;
      sh_d   = '0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= '0;
    end else if (pins_en) begin
      pins_q <= pins_d;
    end
  end

  // R8: no launch, no pin change
  p_hold_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !cfg_load) |=> $stable(pins_q));

  // R2: a refill presents a whole word
  p_refill_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cfg_load) |=> (cnt_q == FULL_CNT));

  // R1: a launch needs data in the FIFO
  p_launch_has_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (cnt_q != '0));

endmodule

// File: rtl/osp_launch_ctl.sv
module osp_launch_ctl
  import osp_pkg::*;
#(
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_mode,
  input  logic              port_tick,
  input  logic              rdy_in,
  input  logic              has_data,
  input  logic              tw_pend,
  input  logic [TIME_W-1:0] tw_target,
  input  logic [TIME_W-1:0] port_count,
  output logic              go,
  output logic              tw_fire,
  output logic              rdy_out
);

  rdy_mode_e mode_q;
  logic      obey_in, drive_out, in_ok, time_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RDY_NONE;
    end else if (cfg_load) begin
      mode_q <= rdy_mode_e'(cfg_mode);
    end
  end

  assign obey_in   = (mode_q == RDY_SLAVE) || (mode_q == RDY_BOTH);
  assign drive_out = (mode_q == RDY_MASTER) || (mode_q == RDY_BOTH);
  assign in_ok     = !obey_in || rdy_in;
  assign tw_fire   = port_tick && tw_pend && (port_count == tw_target);
  assign time_ok   = !tw_pend || tw_fire;
  assign go        = port_tick && has_data && in_ok && time_ok;
  assign rdy_out   = drive_out && has_data && !tw_pend;

  // R6 / R7: a low incoming ready in a gated mode never launches
  p_gate_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (obey_in && !rdy_in) |-> !go);

  // R9: the strobe stays down while a timed write waits
  p_timed_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tw_pend |-> !rdy_out);

endmodule

// File: rtl/strobed_ser_out.sv
module strobed_ser_out
  import osp_pkg::*;
#(
  parameter int unsigned PIN_W  = 4,
  parameter int unsigned XFER_W = 32,
  parameter int unsigned TIME_W = DEF_TIME_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_mode,
  input  logic [PIN_W-1:0]  cfg_init,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [XFER_W-1:0] wr_data,
  input  logic              wr_timed,
  input  logic [TIME_W-1:0] wr_time,
  input  logic              port_tick,
  input  logic [TIME_W-1:0] port_count,
  input  logic              rdy_in,
  output logic              rdy_out,
  output logic [PIN_W-1:0]  pins
);

  logic              rst_meta, rst_q;
  logic              go, tw_fire, take, has_data;
  logic              xr_full, tw_pend;
  logic [XFER_W-1:0] xr_data;
  logic [TIME_W-1:0] tw_target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  osp_xfer_reg #(.XFER_W(XFER_W), .TIME_W(TIME_W)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_q),
    .cfg_load  (cfg_load),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .wr_timed  (wr_timed),
    .wr_time   (wr_time),
    .take      (take),
    .tw_fire   (tw_fire),
    .wr_ready  (wr_ready),
    .xr_data   (xr_data),
    .xr_full   (xr_full),
    .tw_pend   (tw_pend),
    .tw_target (tw_target)
  );

  osp_shifter #(.PIN_W(PIN_W), .XFER_W(XFER_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_q),
    .cfg_load (cfg_load),
    .cfg_init (cfg_init),
    .go       (go),
    .xr_full  (xr_full),
    .xr_data  (xr_data),
    .take     (take),
    .has_data (has_data),
    .pins     (pins)
  );

  osp_launch_ctl #(.TIME_W(TIME_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_q),
    .cfg_load   (cfg_load),
    .cfg_mode   (cfg_mode),
    .port_tick  (port_tick),
    .rdy_in     (rdy_in),
    .has_data   (has_data),
    .tw_pend    (tw_pend),
    .tw_target  (tw_target),
    .port_count (port_count),
    .go         (go),
    .tw_fire    (tw_fire),
    .rdy_out    (rdy_out)
  );

  // R11: pins move only on a tick or a configure
  p_tick_only_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (!port_tick && !cfg_load) |=> $stable(pins));

  // R10: configure places the initial value
  p_cfg_init_r10: assert property (@(posedge clk) disable iff (!rst_q)
    cfg_load |=> (pins == $past(cfg_init)));

  // R9: pins frozen while a timed write waits for its match
  p_timed_hold_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (tw_pend && !tw_fire && !cfg_load) |=> $stable(pins));

endmodule

// File: tb/test_strobed_ser_out.sv
`timescale 1ns/1ps
module test_strobed_ser_out;

  localparam int unsigned PIN_W  = 4;
  localparam int unsigned XFER_W = 32;
  localparam int unsigned TIME_W = 16;
  localparam int unsigned NELEM  = XFER_W / PIN_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_load;
  logic [1:0]        cfg_mode;
  logic [PIN_W-1:0]  cfg_init;
  logic              wr_valid;
  logic              wr_ready;
  logic [XFER_W-1:0] wr_data;
  logic              wr_timed;
  logic [TIME_W-1:0] wr_time;
  logic              port_tick;
  logic [TIME_W-1:0] port_count;
  logic              rdy_in;
  logic              rdy_out;
  logic [PIN_W-1:0]  pins;

  always #2 clk = ~clk;

  strobed_ser_out #(.PIN_W(PIN_W), .XFER_W(XFER_W), .TIME_W(TIME_W)) i_strobed_ser_out (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_init(cfg_init), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_timed(wr_timed), .wr_time(wr_time),
    .port_tick(port_tick), .port_count(port_count), .rdy_in(rdy_in),
    .rdy_out(rdy_out), .pins(pins)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string tag      = "R10";
  int    gcyc     = 0;
  logic [TIME_W-1:0] pc = '0;

  // words waiting to be written (bench side)
  logic [XFER_W-1:0] wq[$];
  bit                tq[$];
  logic [TIME_W-1:0] ttq[$];

  // requirement-level model of the port
  logic [XFER_W-1:0] m_sh, m_xr;
  int                m_cnt;
  bit                m_full, m_pend;
  logic [TIME_W-1:0] m_tgt;
  logic [PIN_W-1:0]  m_pins;
  logic [1:0]        m_mode;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", rq, what, act, exp, gcyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic push(input logic [XFER_W-1:0] w, input bit timed, input logic [TIME_W-1:0] t);
    wq.push_back(w); tq.push_back(timed); ttq.push_back(t);
  endtask

  // one system cycle: check state at negedge, drive, predict the edge
  task automatic cyc(input bit tk, input bit rin, input bit ld,
                     input logic [1:0] md, input logic [PIN_W-1:0] ini);
    bit acc, rel, go, take, ready_exp, rout_exp;
    @(negedge clk);
    ready_exp = !m_full && !m_pend;
    rout_exp  = m_mode[0] && (m_cnt != 0) && !m_pend;
    chk(pins == m_pins, tag, "pins", pins, m_pins);
    chk(wr_ready == ready_exp, "R3", "wr_ready", wr_ready, ready_exp);
    chk(rdy_out == rout_exp, tag, "rdy_out", rdy_out, rout_exp);
    port_tick  = tk;
    rdy_in     = rin;
    port_count = pc;
    cfg_load   = ld;
    cfg_mode   = md;
    cfg_init   = ini;
    wr_valid   = (wq.size() > 0);
    wr_data    = wr_valid ? wq[0] : '0;
    wr_timed   = wr_valid ? tq[0] : 1'b0;
    wr_time    = wr_valid ? ttq[0] : '0;
    acc  = wr_valid && ready_exp;
    rel  = tk && m_pend && (pc == m_tgt);
    go   = tk && (m_cnt != 0) && (!m_mode[1] || rin) && (!m_pend || rel);
    take = m_full && ((m_cnt == 0) || (go && m_cnt == 1));
    if (go) begin
      m_pins = m_sh[PIN_W-1:0];
      m_sh   = m_sh >> PIN_W;
      m_cnt--;
    end
    if (take) begin
      m_sh = m_xr; m_cnt = NELEM; m_full = 0;
    end
    if (acc) begin
      m_xr = wq[0]; m_full = 1;
      if (tq[0]) begin m_pend = 1; m_tgt = ttq[0]; end
      void'(wq.pop_front()); void'(tq.pop_front()); void'(ttq.pop_front());
    end
    if (rel) m_pend = 0;
    if (ld) begin
      m_pins = ini; m_sh = '0; m_cnt = 0; m_full = 0; m_pend = 0; m_mode = md;
    end
    if (tk) pc = pc + 1'b1;
    gcyc++;
    @(posedge clk);
  endtask

  // rpat 0: ready-in high, 1: low, 2: patterned
  task automatic run(input int n, input int tdiv, input int rpat);
    for (int i = 0; i < n; i++) begin
      bit tk, rin;
      tk  = ((gcyc % tdiv) == 0);
      rin = (rpat == 0) ? 1'b1 : (rpat == 1) ? 1'b0 : (((gcyc * 7 + 3) % 5) < 3);
      cyc(tk, rin, 1'b0, m_mode, '0);
    end
  endtask

  task automatic cfg(input logic [1:0] md, input logic [PIN_W-1:0] ini);
    wq.delete(); tq.delete(); ttq.delete();
    tag = "R10";
    cyc(1'b0, 1'b0, 1'b1, md, ini);
    cyc(1'b0, 1'b0, 1'b0, md, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_load = 0; cfg_mode = 0; cfg_init = 0; wr_valid = 0;
    wr_data = 0; wr_timed = 0; wr_time = 0; port_tick = 0; port_count = 0; rdy_in = 0;
    m_sh = '0; m_xr = '0; m_cnt = 0; m_full = 0; m_pend = 0; m_tgt = '0;
    m_pins = '0; m_mode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R10: reset state, held through the synchroniser
    tag = "R10";
    repeat (4) cyc(1'b0, 1'b0, 1'b0, 2'b00, '0);

    // R10: configure loads the pins
    cfg(2'b00, 4'hA);

    // R1: element order, implicit mode, tick every cycle
    cfg(2'b00, 4'h0);
    tag = "R1";
    push(32'h76543210, 0, '0); push(32'hFEDCBA98, 0, '0);
    run(30, 1, 0);

    // R4: implicit mode ignores a low ready-in
    cfg(2'b00, 4'h5);
    tag = "R4";
    push(32'h13579BDF, 0, '0);
    run(20, 1, 1);

    // R11: sparse ticks
    tag = "R11";
    push(32'h2468ACE0, 0, '0);
    run(40, 3, 2);

    // R5: master strobe follows FIFO occupancy, ready-in ignored
    cfg(2'b01, 4'h3);
    tag = "R5";
    push(32'h0F1E2D3C, 0, '0); push(32'h4B5A6978, 0, '0); push(32'h8796A5B4, 0, '0);
    run(70, 2, 1);

    // R6: slave mode gates on ready-in
    cfg(2'b10, 4'hC);
    tag = "R6";
    push(32'hCAFE1234, 0, '0); push(32'h9ABCDEF0, 0, '0);
    run(10, 1, 1);
    run(50, 1, 2);

    // R7: handshake mode
    cfg(2'b11, 4'h1);
    tag = "R7";
    push(32'h5A5AA5A5, 0, '0); push(32'h31415926, 0, '0);
    run(70, 2, 2);

    // R2: back-to-back words stream without gaps
    cfg(2'b00, 4'h0);
    tag = "R2";
    for (int k = 0; k < 4; k++) push(32'h11111111 * (k + 1) + 32'h01234567, 0, '0);
    run(45, 1, 0);

    // R8: starved port holds the last element
    tag = "R8";
    run(15, 1, 0);

    // R9: timed write in master mode, with a second write waiting behind it
    cfg(2'b01, 4'h0);
    tag = "R9";
    push(32'hA1B2C3D4, 1, pc + 16'd12);
    push(32'hE5F60718, 0, '0);
    run(50, 1, 0);

    // R9: timed write in handshake mode with patterned ready-in
    cfg(2'b11, 4'h7);
    tag = "R9";
    push(32'h89ABCDEF, 1, pc + 16'd7);
    run(45, 1, 2);

    // sweep of modes against tick spacing (R4, R5, R6, R7)
    for (int m = 0; m < 4; m++) begin
      for (int td = 1; td <= 3; td++) begin
        cfg(m[1:0], 4'(m + td));
        tag = (m == 0) ? "R4" : (m == 1) ? "R5" : (m == 2) ? "R6" : "R7";
        push(32'h9E3779B9 * (m * 3 + td), 0, '0);
        push(32'h7F4A7C15 ^ (m * 16 + td), 0, '0);
        run(16 * td * 2 + 10, td, 2);
      end
    end

    done = 1;
    summary();
  end

endmodule